// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation cache. Each slot stores a virtual page number, a 12-bit address-space tag, a physical page number and an attribute set. The attributes are a page-size code, a global flag, a privilege level, a memory-type code and a dirty flag. Each slot also has a valid flag. The lookup path is purely combinational: a virtual page number and the current address-space tag go in, and in the same cycle the block returns hit, the physical page and the attributes. The page-size code is only stored and returned. It does not widen the match.

A fill port installs one translation per accepted beat. A command port removes translations at several granularities:
- every slot;
- every slot that is not global;
- every non-global slot of one address space;
- one page within one address space;
- one page in every address space, global slots included.

Global translations match under any current tag. Per-space commands leave them in place. A surrounding page-walk engine and flush sequencer drive the ports.

Both write-side ports are valid/ready. `cmd_ready` is always 1, so a command is accepted in the cycle its `cmd_valid` is high. `fill_ready` is low whenever `cmd_valid` is high. A fill offered in such a cycle is not taken and must be held until `fill_ready` returns. Lookup has no handshake.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits when a valid slot has the same page number and either its global flag is 1 or its stored tag equals `lk_asid`. Hit, page and attributes appear in the same cycle. On a miss, every lookup output is 0. If several slots match, the lowest-numbered slot supplies the result.
- R2: One virtual page may be resident under two tags at once. Each tag's lookup returns its own physical page.
- R3: A slot with the global flag set hits for any value of `lk_asid`.
- R4: An accepted fill is visible to lookups from the next cycle, not in its own cycle. A fill whose page and tag both equal a valid slot overwrites that slot, so no second copy arises.
- R5: A fill with no such match goes to the lowest-numbered invalid slot. If every slot is valid, it goes to a rotating victim slot. The victim starts at 0 after reset and advances by one, wrapping, only on each fill of this kind.
- R6: Command code 0 clears every slot, global ones included.
- R7: Command code 1 clears every slot whose global flag is 0 and keeps global slots.
- R8: Command code 2 clears the non-global slots whose tag equals `cmd_asid`. Slots of other tags, and global slots, remain.
- R9: Command code 3 clears the non-global slots whose page equals `cmd_vpn` and whose tag equals `cmd_asid`.
- R10: Command code 4 clears every slot whose page equals `cmd_vpn`, whatever its tag and global flag.
- R11: A command changes lookup results from the next cycle. A lookup in the command's own cycle still sees the old contents. `cmd_done` pulses for one cycle, one cycle after each accepted command. Codes 5 to 7 change nothing but still pulse `cmd_done`.
- R12: After reset every slot is invalid and `cmd_done` is 0. `cmd_ready` is always 1. `fill_ready` equals the inverse of `cmd_valid`, so a command takes priority and a fill offered with it writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_pgsz | output | 2 | Page-size code of the hit |
| lk_glob | output | 1 | Global flag of the hit |
| lk_priv | output | 2 | Privilege level of the hit |
| lk_mtype | output | 2 | Memory-type code of the hit |
| lk_dirty | output | 1 | Dirty flag of the hit |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_vpn | input | VPN_W | Fill virtual page |
| fill_asid | input | ASID_W | Fill tag |
| fill_ppn | input | PPN_W | Fill physical page |
| fill_pgsz | input | 2 | Fill page-size code |
| fill_glob | input | 1 | Fill global flag |
| fill_priv | input | 2 | Fill privilege level |
| fill_mtype | input | 2 | Fill memory-type code |
| fill_dirty | input | 1 | Fill dirty flag |
| cmd_valid | input | 1 | Invalidate command offered |
| cmd_ready | output | 1 | Always 1 |
| cmd_op | input | 3 | Command code (0 to 4; others have no effect) |
| cmd_vpn | input | VPN_W | Page operand for codes 3 and 4 |
| cmd_asid | input | ASID_W | Tag operand for codes 2 and 3 |
| cmd_done | output | 1 | One-cycle pulse after each command |

## Verification
Lookup results are due in the cycle their inputs are applied. Their effect on contents is due one edge later: a fill or command applied before edge k changes lookups from the cycle after edge k. `cmd_done` is due in that same cycle. The bench drives inputs just after a falling edge and samples a few time units later, before the next rising edge. It advances its behavioural table model only after that rising edge. Each comparison therefore sees old contents for the same-cycle case and new contents one cycle on. Directed sequences place a lookup in the command's own cycle and in the next cycle to pin down this latency.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PGSZ_W  = 2;
  localparam int PRIV_W  = 2;
  localparam int MTYPE_W = 2;

  typedef enum logic [2:0] {
    OP_ALL        = 3'd0,
    OP_LOCAL      = 3'd1,
    OP_SPACE      = 3'd2,
    OP_PAGE_SPACE = 3'd3,
    OP_PAGE_ANY   = 3'd4
  } tlb_op_e;

  typedef struct packed {
    logic [PGSZ_W-1:0]  pgsz;
    logic               glob;
    logic [PRIV_W-1:0]  priv;
    logic [MTYPE_W-1:0] mtype;
    logic               dirty;
  } tlb_attr_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 12
) (
  input  logic [N-1:0][VPN_W-1:0]  e_vpn,
  input  logic [N-1:0][ASID_W-1:0] e_asid,
  input  logic [N-1:0]             e_valid,
  input  logic [N-1:0]             e_glob,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [ASID_W-1:0]        fill_asid,
  input  tlb_pkg::tlb_op_e         op,
  input  logic [VPN_W-1:0]         cmd_vpn,
  input  logic [ASID_W-1:0]        cmd_asid,
  output logic [N-1:0]             lk_vec,
  output logic [N-1:0]             fill_vec,
  output logic [N-1:0]             kill_vec
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic page_eq;
    logic space_eq;
    logic kill;

    assign page_eq  = (e_vpn[i] == cmd_vpn);
    assign space_eq = (e_asid[i] == cmd_asid);

    assign lk_vec[i] = e_valid[i] && (e_vpn[i] == lk_vpn) &&
                       (e_glob[i] || (e_asid[i] == lk_asid));
    assign fill_vec[i] = e_valid[i] && (e_vpn[i] == fill_vpn) &&
                         (e_asid[i] == fill_asid);

    always_comb begin
      case (op)
        tlb_pkg::OP_ALL:        kill = 1'b1;
        tlb_pkg::OP_LOCAL:      kill = !e_glob[i];
        tlb_pkg::OP_SPACE:      kill = space_eq && !e_glob[i];
        tlb_pkg::OP_PAGE_SPACE: kill = page_eq && space_eq && !e_glob[i];
        tlb_pkg::OP_PAGE_ANY:   kill = page_eq;
        default:                kill = 1'b0;
      endcase
    end
    assign kill_vec[i] = kill;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     same_vec,
  input  logic             take,
  output logic [IDX_W-1:0] sel
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_same;
  logic             full;

  assign any_same = |same_vec;
  assign full     = &valid;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (same_vec[i]) same_idx = IDX_W'(i);
      if (!valid[i])   free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (any_same)   sel = same_idx;
    else if (!full) sel = free_idx;
    else            sel = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && !any_same && full) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [1:0]        lk_pgsz,
  output logic              lk_glob,
  output logic [1:0]        lk_priv,
  output logic [1:0]        lk_mtype,
  output logic              lk_dirty,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_pgsz,
  input  logic              fill_glob,
  input  logic [1:0]        fill_priv,
  input  logic [1:0]        fill_mtype,
  input  logic              fill_dirty,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [ASID_W-1:0] cmd_asid,
  output logic              cmd_done
);
  import tlb_pkg::*;
  localparam int IDX_W = $clog2(N);

  logic [N-1:0][VPN_W-1:0]  e_vpn;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0][PPN_W-1:0]  e_ppn;
  tlb_attr_t [N-1:0]        e_attr;
  logic [N-1:0]             e_valid;
  logic [N-1:0]             e_glob;
  logic [N-1:0]             lk_vec, fill_vec, kill_vec;
  logic [IDX_W-1:0]         wr_idx;
  logic                     fill_take;
  tlb_attr_t                fill_attr;
  tlb_attr_t                hit_attr;

  for (genvar i = 0; i < N; i++) begin : g_glob
    assign e_glob[i] = e_attr[i].glob;
  end

  assign cmd_ready  = 1'b1;
  assign fill_ready = !cmd_valid;
  assign fill_take  = fill_valid && fill_ready;
  assign fill_attr  = '{pgsz: fill_pgsz, glob: fill_glob, priv: fill_priv,
                        mtype: fill_mtype, dirty: fill_dirty};

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .e_vpn    (e_vpn),
    .e_asid   (e_asid),
    .e_valid  (e_valid),
    .e_glob   (e_glob),
    .lk_vpn   (lk_vpn),
    .lk_asid  (lk_asid),
    .fill_vpn (fill_vpn),
    .fill_asid(fill_asid),
    .op       (tlb_op_e'(cmd_op)),
    .cmd_vpn  (cmd_vpn),
    .cmd_asid (cmd_asid),
    .lk_vec   (lk_vec),
    .fill_vec (fill_vec),
    .kill_vec (kill_vec)
  );

  tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .valid   (e_valid),
    .same_vec(fill_vec),
    .take    (fill_take),
    .sel     (wr_idx)
  );

  // Valid flags and the done pulse carry reset; payload does not.
  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid  <= '0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= cmd_valid;
      if (cmd_valid)      e_valid <= e_valid & ~kill_vec;
      else if (fill_take) e_valid[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_take) begin
      e_vpn[wr_idx]  <= fill_vpn;
      e_asid[wr_idx] <= fill_asid;
      e_ppn[wr_idx]  <= fill_ppn;
      e_attr[wr_idx] <= fill_attr;
    end
  end

  // Lowest-numbered matching slot wins.
  always_comb begin
    lk_ppn   = '0;
    hit_attr = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_vec[i]) begin
        lk_ppn   = e_ppn[i];
        hit_attr = e_attr[i];
      end
    end
  end

  assign lk_hit   = |lk_vec;
  assign lk_pgsz  = hit_attr.pgsz;
  assign lk_glob  = hit_attr.glob;
  assign lk_priv  = hit_attr.priv;
  assign lk_mtype = hit_attr.mtype;
  assign lk_dirty = hit_attr.dirty;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       cmd_done,
  input logic       fill_ready,
  input logic       lk_hit,
  input logic       lk_glob
);
  AST_DONE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> cmd_done); // R11
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> $past(cmd_valid)); // R11
  AST_CMD_BLOCKS_FILL: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !fill_ready); // R12
  AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd0) |=> !lk_hit); // R6
  AST_LOCAL_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1) |=> (!lk_hit || lk_glob)); // R7
endmodule

bind asid_tlb asid_tlb_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_done  (cmd_done),
  .fill_ready(fill_ready),
  .lk_hit    (lk_hit),
  .lk_glob   (lk_glob)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [19:0] lk_vpn = '0, fill_vpn = '0, cmd_vpn = '0;
  logic [11:0] lk_asid = '0, fill_asid = '0, cmd_asid = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_pgsz = '0, fill_priv = '0, fill_mtype = '0;
  logic        fill_glob = 1'b0, fill_dirty = 1'b0;
  logic        fill_valid = 1'b0, cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        lk_hit, lk_glob, lk_dirty, fill_ready, cmd_ready, cmd_done;
  logic [19:0] lk_ppn;
  logic [1:0]  lk_pgsz, lk_priv, lk_mtype;

  asid_tlb u_asid_tlb (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model
  logic [19:0] m_vpn [N];
  logic [11:0] m_asid[N];
  logic [19:0] m_ppn [N];
  logic [7:0]  m_attr[N]; // {pgsz, glob, priv, mtype, dirty}
  bit          m_v   [N];
  int          m_rr = 0;
  bit          m_done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] model_look(input logic [19:0] v, input logic [11:0] a);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v && (m_attr[i][5] || m_asid[i] == a))
        return {1'b1, m_ppn[i], m_attr[i]};
    return '0;
  endfunction

  task automatic model_update();
    m_done = cmd_valid;
    if (cmd_valid) begin
      for (int i = 0; i < N; i++) begin
        bit g = m_attr[i][5];
        bit k;
        case (cmd_op)
          3'd0: k = 1;
          3'd1: k = !g;
          3'd2: k = !g && m_asid[i] == cmd_asid;
          3'd3: k = !g && m_asid[i] == cmd_asid && m_vpn[i] == cmd_vpn;
          3'd4: k = m_vpn[i] == cmd_vpn;
          default: k = 0;
        endcase
        if (k) m_v[i] = 0;
      end
    end else if (fill_valid) begin
      int slot = -1;
      for (int i = 0; i < N; i++)
        if (slot < 0 && m_v[i] && m_vpn[i] == fill_vpn && m_asid[i] == fill_asid) slot = i;
      for (int i = 0; i < N; i++)
        if (slot < 0 && !m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1;
      m_vpn[slot] = fill_vpn;
      m_asid[slot] = fill_asid;
      m_ppn[slot] = fill_ppn;
      m_attr[slot] = {fill_pgsz, fill_glob, fill_priv, fill_mtype, fill_dirty};
    end
  endtask

  // called just after a falling edge with inputs applied
  task automatic tick();
    logic [28:0] exp_l, act_l;
    #2;
    exp_l = model_look(lk_vpn, lk_asid);
    act_l = {lk_hit, lk_ppn, lk_pgsz, lk_glob, lk_priv, lk_mtype, lk_dirty};
    chk(act_l === exp_l, "R1 lookup vs model", act_l, exp_l);
    chk(cmd_done === m_done, "R11 done pulse", cmd_done, m_done);
    chk(fill_ready === !cmd_valid && cmd_ready === 1'b1, "R12 handshake",
        {fill_ready, cmd_ready}, {!cmd_valid, 1'b1});
    @(posedge clk); #1;
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    fill_valid = 0; cmd_valid = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [11:0] a, input logic [19:0] p, input bit g);
    idle();
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_glob = g;
    fill_pgsz = p[1:0]; fill_priv = p[3:2]; fill_mtype = p[5:4]; fill_dirty = p[6];
    tick();
    idle();
  endtask

  task automatic cmd(input logic [2:0] op, input logic [19:0] v, input logic [11:0] a);
    idle();
    cmd_valid = 1; cmd_op = op; cmd_vpn = v; cmd_asid = a;
    tick();
    idle();
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] a, input bit eh,
                      input logic [19:0] ep, input string req);
    lk_vpn = v; lk_asid = a;
    #1;
    chk(lk_hit === eh, req, lk_hit, eh);
    if (eh) chk(lk_ppn === ep, req, lk_ppn, ep);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_attr[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R12 reset state
    chk(cmd_done === 1'b0, "R12 reset done low", cmd_done, 0);
    look(20'h100, 12'd5, 0, 0, "R12 reset empty");

    // R4 fill not visible in its own cycle, visible next
    lk_vpn = 20'h100; lk_asid = 12'd5;
    fill(20'h100, 12'd5, 20'h00AAA, 0);
    look(20'h100, 12'd5, 1, 20'h00AAA, "R4 fill visible next cycle");

    // R2 same page under two tags
    fill(20'h100, 12'd6, 20'h00BBB, 0);
    look(20'h100, 12'd5, 1, 20'h00AAA, "R2 tag 5 own page");
    look(20'h100, 12'd6, 1, 20'h00BBB, "R2 tag 6 own page");
    look(20'h100, 12'd7, 0, 0, "R1 other tag misses");

    // R3 global matches any tag
    fill(20'h200, 12'd1, 20'h00CCC, 1);
    look(20'h200, 12'd77, 1, 20'h00CCC, "R3 global any tag");

    // R4 overwrite same page+tag
    fill(20'h100, 12'd5, 20'h00DDD, 0);
    look(20'h100, 12'd5, 1, 20'h00DDD, "R4 overwrite");
    // R9 single page in space removes the only copy
    cmd(3'd3, 20'h100, 12'd5);
    look(20'h100, 12'd5, 0, 0, "R9 page in space cleared, no duplicate");
    look(20'h100, 12'd6, 1, 20'h00BBB, "R9 other tag kept");
    // R9 global untouched by page-in-space
    cmd(3'd3, 20'h200, 12'd1);
    look(20'h200, 12'd1, 1, 20'h00CCC, "R9 global kept");

    // R11 command same cycle sees old contents, then R7
    lk_vpn = 20'h100; lk_asid = 12'd6;
    idle(); cmd_valid = 1; cmd_op = 3'd1;
    #1 chk(lk_hit === 1'b1, "R11 same-cycle lookup old", lk_hit, 1);
    tick(); idle();
    chk(cmd_done === 1'b1, "R11 done one cycle later", cmd_done, 1);
    look(20'h100, 12'd6, 0, 0, "R7 local cleared");
    chk(cmd_done === 1'b0, "R11 done single pulse", cmd_done, 0);
    look(20'h200, 12'd3, 1, 20'h00CCC, "R7 global kept");

    // R8 per-space
    fill(20'h300, 12'd6, 20'h00E01, 0);
    fill(20'h301, 12'd5, 20'h00E02, 0);
    fill(20'h302, 12'd6, 20'h00E03, 1);
    cmd(3'd2, 20'h0, 12'd6);
    look(20'h300, 12'd6, 0, 0, "R8 space cleared");
    look(20'h301, 12'd5, 1, 20'h00E02, "R8 other space kept");
    look(20'h302, 12'd6, 1, 20'h00E03, "R8 global kept");

    // R11 undefined code changes nothing
    cmd(3'd6, 20'h301, 12'd5);
    chk(cmd_done === 1'b1, "R11 undefined code done", cmd_done, 1);
    look(20'h301, 12'd5, 1, 20'h00E02, "R11 undefined code no effect");

    // R10 page in every space, global included
    cmd(3'd4, 20'h200, 12'd0);
    look(20'h200, 12'd1, 0, 0, "R10 global page cleared");
    look(20'h302, 12'd6, 1, 20'h00E03, "R10 other page kept");

    // R12 fill blocked by command
    idle(); cmd_valid = 1; cmd_op = 3'd7;
    fill_valid = 1; fill_vpn = 20'h777; fill_asid = 12'd2; fill_ppn = 20'h1; fill_glob = 0;
    tick(); idle();
    look(20'h777, 12'd2, 0, 0, "R12 blocked fill not written");

    // R6 everything
    cmd(3'd0, 20'h0, 12'd0);
    look(20'h302, 12'd6, 0, 0, "R6 global cleared by all");
    look(20'h301, 12'd5, 0, 0, "R6 all cleared");

    // R5 placement
    for (int k = 0; k < N; k++) fill(20'h400 + 20'(k), 12'd2, 20'h10 + 20'(k), 0);
    cmd(3'd3, 20'h405, 12'd2);
    fill(20'h600, 12'd2, 20'h00600, 0);  // to free slot 5
    for (int j = 0; j < 3; j++) fill(20'h500 + 20'(j), 12'd2, 20'h50 + 20'(j), 0);
    look(20'h600, 12'd2, 1, 20'h00600, "R5 free slot used first");
    look(20'h400, 12'd2, 0, 0, "R5 victim slot 0");
    look(20'h402, 12'd2, 0, 0, "R5 victim slot 2");
    look(20'h403, 12'd2, 1, 20'h13, "R5 slot 3 kept");
    look(20'h502, 12'd2, 1, 20'h52, "R5 new entry present");

    // mixed traffic against the model
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 99);
      idle();
      lk_vpn = 20'($urandom_range(0, 15)); lk_asid = 12'($urandom_range(0, 3));
      if (r < 45) begin
        fill_valid = 1; fill_vpn = 20'($urandom_range(0, 15)); fill_asid = 12'($urandom_range(0, 3));
        fill_ppn = 20'($urandom); fill_glob = ($urandom_range(0, 5) == 0);
        fill_pgsz = 2'($urandom); fill_priv = 2'($urandom); fill_mtype = 2'($urandom);
        fill_dirty = 1'($urandom);
      end
      if (r >= 40 && r < 52) begin
        cmd_valid = 1;
        cmd_op = ($urandom_range(0, 9) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
        cmd_vpn = 20'($urandom_range(0, 15)); cmd_asid = 12'($urandom_range(0, 3));
      end
      tick();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule